// File: doc/BRIEF.md
# Auto-Ranging Interval Timer

This block measures the spacing between rotor position events with an 8-bit up-counter. The counter is clocked by a programmable power-of-two divider, so a single count stands for 2^k input ticks. Every zero-crossing pulse restarts the count from zero.

In automatic mode the block picks the divider exponent k itself. If the count is about to pass its top value, the counter runs too fast. In that case k goes up by one, the count restarts from the midpoint, and each companion timing register is halved. The intervals then keep the same meaning at the coarser resolution. If a zero-crossing arrives while the count is still low, the counter runs too slowly. In that case k goes down by one and the companion registers are doubled. In software-controlled mode k changes only when it is written explicitly, and an overflow simply wraps the counter.

A sticky ranging flag and a sticky overflow-indication flag record these steps. The ranging flag is also gated with an enable to form an interrupt request.

Top module: `auto_range_timer`

## Requirements
- R1: After reset, the count, the exponent, both flags, the interrupt and all companion registers are zero.
- R2: The count advances by one after every 2^exponent cycles in which `tick_i` is high. It holds while `tick_i` is low and no zero-crossing arrives.
- R3: In automatic mode, when the count would advance past 0xFF and the exponent is below `EXP_MAX`, four things happen on the next cycle. The count becomes 0x80, the exponent rises by one, every companion register is shifted right by one bit, and the ranging flag is set.
- R4: The overflow-indication flag is set by an R3 step only when `test_sel_i` is 2'b00. Any other value leaves it unchanged.
- R5: `irq_o` is high exactly when the ranging flag is set and `rng_ie_i` is high.
- R6: A zero-crossing pulse sets the count to 0 on the next cycle and restarts the divider, in both modes.
- R7: In automatic mode, a zero-crossing that arrives while the count is below 0x55 and the exponent is above 0 does two things. It lowers the exponent by one, and it shifts every companion register left by one bit, keeping the low 8 bits. A count of 0x55 or more leaves both unchanged.
- R8: In software-controlled mode (`auto_i` = 0), the exponent changes only through `exp_we_i`/`exp_wd_i`, and an overflow wraps the count to 0 and sets the ranging flag. Exponent writes made while `auto_i` = 1 have no effect.
- R9: In automatic mode with the exponent at `EXP_MAX`, an overflow wraps the count to 0 and sets the ranging flag, with the exponent and companions unchanged. A low zero-crossing at exponent 0 changes neither.
- R10: When a zero-crossing and an overflow occur in the same cycle, the zero-crossing wins. The count goes to 0, and no ranging step or flag setting takes place.
- R11: `flag_clr_i` clears both flags on the next cycle, unless a ranging step sets them in that same cycle.
- R12: `cmp_we_i[i]` loads `cmp_wd_i` into companion register i. This write takes precedence over a same-cycle rescale. Register i appears at `cmp_o[8*i +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick feeding the divider |
| zc_i | input | 1 | Zero-crossing event pulse |
| auto_i | input | 1 | 1 = automatic ranging, 0 = software-controlled |
| exp_we_i | input | 1 | Exponent write strobe (software-controlled mode) |
| exp_wd_i | input | EXP_W | Exponent write value, clipped to EXP_MAX |
| test_sel_i | input | 2 | Test-select field gating the overflow indication |
| rng_ie_i | input | 1 | Ranging interrupt enable |
| flag_clr_i | input | 1 | Clears both sticky flags |
| cmp_we_i | input | NCMP | Per-register companion write strobes |
| cmp_wd_i | input | CNT_W | Companion write data |
| count_o | output | CNT_W | Current count |
| exp_o | output | EXP_W | Divider exponent |
| rng_flag_o | output | 1 | Sticky ranging flag |
| ovf_flag_o | output | 1 | Sticky overflow-indication flag |
| irq_o | output | 1 | Ranging interrupt request |
| cmp_o | output | NCMP*CNT_W | Companion registers, packed |

## Verification
A corrupt exponent shows at `exp_o` on the next cycle. It also shows within one count period as the wrong spacing of `count_o` increments. A divider that has slipped moves the cycle in which the count steps, and the bench sees this within 2^exponent cycles. A missed or doubled rescale leaves every companion value at `cmp_o` off by a factor of two from the cycle after the step. A wrong ranging decision shows one cycle later as a count of 0x80 where 0x00 was due, or the reverse.

// File: rtl/ait_pkg.sv
package ait_pkg;

  // Rescale action applied to the companion registers in one cycle.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SLOW = 2'd1,  // range up: values halved
    ACT_FAST = 2'd2   // range down: values doubled
  } rng_act_e;

endpackage

// File: rtl/ait_presc.sv
module ait_presc #(
  parameter int EXP_MAX = 15,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [EXP_W-1:0] expo,
  output logic             adv
);

  localparam int DIV_W = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;

  // Number of ticks per count, minus one: 2^e - 1.
  function automatic logic [DIV_W:0] tick_span(input logic [EXP_W-1:0] e);
    return ((DIV_W+1)'(1) << e) - (DIV_W+1)'(1);
  endfunction

  assign span = tick_span(expo);
  assign adv  = tick && (div_q == span[DIV_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (adv)     div_q <= '0;
    else if (tick)    div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/ait_core.sv
module ait_core
  import ait_pkg::*;
#(
  parameter int             CNT_W   = 8,
  parameter int             EXP_MAX = 15,
  parameter int             EXP_W   = 4,
  parameter logic [CNT_W-1:0] LOW_TH = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             zc,
  input  logic             auto_mode,
  input  logic             exp_we,
  input  logic [EXP_W-1:0] exp_wd,
  input  logic [1:0]       test_sel,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic [EXP_W-1:0] expo,
  output logic             rng_flag,
  output logic             ovf_flag,
  output logic             exp_load,
  output logic             ev_slow,
  output logic             ev_fast,
  output logic             ev_wrap,
  output rng_act_e         act
);

  localparam logic [CNT_W-1:0] MID  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [EXP_W-1:0] EMAX = EXP_W'(EXP_MAX);

  logic at_top, can_slow;

  function automatic logic [EXP_W-1:0] clip_exp(input logic [EXP_W-1:0] e);
    return (e > EMAX) ? EMAX : e;
  endfunction

  assign at_top   = (count == '1);
  assign can_slow = auto_mode && (expo < EMAX);
  assign ev_slow  = adv && at_top && !zc && can_slow;
  assign ev_wrap  = adv && at_top && !zc && !can_slow;
  assign ev_fast  = zc && auto_mode && (count < LOW_TH) && (expo != '0);
  assign exp_load = exp_we && !auto_mode;

  always_comb begin
    act = ACT_HOLD;
    if (ev_slow)      act = ACT_SLOW;
    else if (ev_fast) act = ACT_FAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      expo     <= '0;
      rng_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (zc)           count <= '0;
      else if (ev_slow) count <= MID;
      else if (ev_wrap) count <= '0;
      else if (adv)     count <= count + 1'b1;

      if (ev_slow)       expo <= expo + 1'b1;
      else if (ev_fast)  expo <= expo - 1'b1;
      else if (exp_load) expo <= clip_exp(exp_wd);

      if (ev_slow || ev_wrap) rng_flag <= 1'b1;
      else if (flag_clr)      rng_flag <= 1'b0;

      if (ev_slow && test_sel == 2'b00) ovf_flag <= 1'b1;
      else if (flag_clr)                ovf_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/ait_cmp.sv
module ait_cmp
  import ait_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NCMP  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rng_act_e              act,
  input  logic [NCMP-1:0]       we,
  input  logic [CNT_W-1:0]      wd,
  output logic [NCMP*CNT_W-1:0] vals
);

  function automatic logic [CNT_W-1:0] rescale(input logic [CNT_W-1:0] v,
                                               input rng_act_e a);
    case (a)
      ACT_SLOW: return v >> 1;
      ACT_FAST: return v << 1;
      default:  return v;
    endcase
  endfunction

  for (genvar i = 0; i < NCMP; i++) begin : g_reg
    logic [CNT_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     r_q <= '0;
      else if (we[i]) r_q <= wd;
      else            r_q <= rescale(r_q, act);
    end
    assign vals[i*CNT_W +: CNT_W] = r_q;
  end

endmodule

// File: rtl/auto_range_timer.sv
module auto_range_timer
  import ait_pkg::*;
#(
  parameter int               CNT_W   = 8,
  parameter int               EXP_MAX = 15,
  parameter int               NCMP    = 3,
  parameter logic [CNT_W-1:0] LOW_TH  = 8'h55,
  localparam int              EXP_W   = $clog2(EXP_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  zc_i,
  input  logic                  auto_i,
  input  logic                  exp_we_i,
  input  logic [EXP_W-1:0]      exp_wd_i,
  input  logic [1:0]            test_sel_i,
  input  logic                  rng_ie_i,
  input  logic                  flag_clr_i,
  input  logic [NCMP-1:0]       cmp_we_i,
  input  logic [CNT_W-1:0]      cmp_wd_i,
  output logic [CNT_W-1:0]      count_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic                  rng_flag_o,
  output logic                  ovf_flag_o,
  output logic                  irq_o,
  output logic [NCMP*CNT_W-1:0] cmp_o
);

  logic     adv;
  logic     exp_load;
  logic     ev_slow, ev_fast, ev_wrap;
  rng_act_e act;

  ait_presc #(.EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .restart (zc_i || exp_load),
    .expo    (exp_o),
    .adv     (adv)
  );

  ait_core #(.CNT_W(CNT_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W), .LOW_TH(LOW_TH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .zc        (zc_i),
    .auto_mode (auto_i),
    .exp_we    (exp_we_i),
    .exp_wd    (exp_wd_i),
    .test_sel  (test_sel_i),
    .flag_clr  (flag_clr_i),
    .count     (count_o),
    .expo      (exp_o),
    .rng_flag  (rng_flag_o),
    .ovf_flag  (ovf_flag_o),
    .exp_load  (exp_load),
    .ev_slow   (ev_slow),
    .ev_fast   (ev_fast),
    .ev_wrap   (ev_wrap),
    .act       (act)
  );

  ait_cmp #(.CNT_W(CNT_W), .NCMP(NCMP)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .we    (cmp_we_i),
    .wd    (cmp_wd_i),
    .vals  (cmp_o)
  );

  assign irq_o = rng_flag_o && rng_ie_i;

endmodule

// File: rtl/ait_chk.sv
module ait_chk #(
  parameter int CNT_W   = 8,
  parameter int EXP_MAX = 15,
  parameter int EXP_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             zc_i,
  input logic             auto_i,
  input logic             exp_we_i,
  input logic [1:0]       test_sel_i,
  input logic [CNT_W-1:0] count_o,
  input logic [EXP_W-1:0] exp_o,
  input logic             rng_flag_o,
  input logic             ovf_flag_o,
  input logic             ev_slow,
  input logic             ev_fast,
  input logic             ev_wrap
);

  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);

  a_r6_zc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    zc_i |=> count_o == '0);

  a_r3_slow_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slow |=> (count_o == MID && exp_o == $past(exp_o) + 1'b1 && rng_flag_o));

  a_r7_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast |=> exp_o == $past(exp_o) - 1'b1);

  a_r4_ovf_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slow && test_sel_i == 2'b00) |=> ovf_flag_o);

  a_r8_manual_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_i && !exp_we_i) |=> exp_o == $past(exp_o));

  a_r9_exp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(exp_o) <= EXP_MAX);

  a_r10_zc_first: assert property (@(posedge clk) disable iff (!rst_n)
    zc_i |-> (!ev_slow && !ev_wrap));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !zc_i) |=> count_o == $past(count_o));

endmodule

bind auto_range_timer ait_chk #(.CNT_W(CNT_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .zc_i       (zc_i),
  .auto_i     (auto_i),
  .exp_we_i   (exp_we_i),
  .test_sel_i (test_sel_i),
  .count_o    (count_o),
  .exp_o      (exp_o),
  .rng_flag_o (rng_flag_o),
  .ovf_flag_o (ovf_flag_o),
  .ev_slow    (ev_slow),
  .ev_fast    (ev_fast),
  .ev_wrap    (ev_wrap)
);

// File: tb/sim_auto_range_timer.sv
module sim_auto_range_timer;

  localparam int EMX = 3;
  localparam int EW  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, zc_i = 1'b0, auto_i = 1'b0, exp_we_i = 1'b0;
  logic [1:0] exp_wd_i = '0, test_sel_i = '0;
  logic       rng_ie_i = 1'b0, flag_clr_i = 1'b0;
  logic [1:0] cmp_we_i = '0;
  logic [7:0] cmp_wd_i = '0;
  logic [7:0] count_o;
  logic [EW-1:0] exp_o;
  logic       rng_flag_o, ovf_flag_o, irq_o;
  logic [15:0] cmp_o;

  auto_range_timer #(.CNT_W(8), .EXP_MAX(EMX), .NCMP(2), .LOW_TH(8'h55)) u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int    cnt, ex, rf, of, irq, c0, c1;
    string tag;
  } item_t;

  item_t q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // Bench-side state and held inputs
  int m_cnt = 0, m_exp = 0, m_div = 0, m_rf = 0, m_of = 0;
  int m_cmp[2] = '{0, 0};
  bit b_tick = 0, b_auto = 0, b_ie = 0;
  int b_ts = 0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Monitor: compare one expected item shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "count", int'(count_o), it.cnt);
        chk(it.tag, "exp", int'(exp_o), it.ex);
        chk(it.tag, "rng_flag", int'(rng_flag_o), it.rf);
        chk(it.tag, "ovf_flag", int'(ovf_flag_o), it.of);
        chk(it.tag, "irq", int'(irq_o), it.irq);
        chk(it.tag, "cmp0", int'(cmp_o[7:0]), it.c0);
        chk(it.tag, "cmp1", int'(cmp_o[15:8]), it.c1);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the state expected after the edge
  task automatic step(input bit zc, input bit ewe, input int ewd, input bit clr,
                      input int cwe, input int cwd, input string tag);
    int  span;
    bit  adv, set_r, set_o;
    item_t it;
    @(negedge clk);
    tick_i = b_tick; auto_i = b_auto; rng_ie_i = b_ie; test_sel_i = 2'(b_ts);
    zc_i = zc; exp_we_i = ewe; exp_wd_i = EW'(ewd); flag_clr_i = clr;
    cmp_we_i = 2'(cwe); cmp_wd_i = 8'(cwd);
    span  = (1 << m_exp) - 1;
    adv   = b_tick && (m_div == span);
    set_r = 0; set_o = 0;
    if (zc) begin
      if (b_auto && m_cnt < 'h55 && m_exp > 0) begin
        m_exp--;
        foreach (m_cmp[c]) m_cmp[c] = (m_cmp[c] * 2) % 256;
      end
      m_cnt = 0; m_div = 0;
    end else if (adv) begin
      m_div = 0;
      if (m_cnt == 255) begin
        set_r = 1;
        if (b_auto && m_exp < EMX) begin
          m_cnt = 'h80; m_exp++;
          foreach (m_cmp[c]) m_cmp[c] = m_cmp[c] / 2;
          set_o = (b_ts == 0);
        end else m_cnt = 0;
      end else m_cnt++;
    end else if (b_tick) m_div++;
    if (!b_auto && ewe) begin m_exp = ewd; m_div = 0; end
    m_rf = set_r ? 1 : (clr ? 0 : m_rf);
    m_of = set_o ? 1 : (clr ? 0 : m_of);
    for (int c = 0; c < 2; c++) if (cwe[c]) m_cmp[c] = cwd;
    it.cnt = m_cnt; it.ex = m_exp; it.rf = m_rf; it.of = m_of;
    it.irq = m_rf & int'(b_ie); it.c0 = m_cmp[0]; it.c1 = m_cmp[1]; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // Advance until the next advance would take the count past 0xFF
  task automatic run_to_top(input string tag);
    while (!(m_cnt == 255 && m_div == (1 << m_exp) - 1)) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "exp", int'(exp_o), 0);
    chk("R1", "flags", int'({rng_flag_o, ovf_flag_o, irq_o}), 0);
    chk("R1", "cmp", int'(cmp_o), 0);
    rst_n = 1'b1;
    idle(2, "R1");

    // R12: companion loads
    step(0, 0, 0, 0, 1, 'h40, "R12");
    step(0, 0, 0, 0, 2, 'h0c, "R12");

    // R2: manual mode, exponent 1, ticks with gaps
    step(0, 1, 1, 0, 0, 0, "R8");
    b_tick = 1; idle(9, "R2");
    b_tick = 0; idle(4, "R2");
    b_tick = 1; idle(6, "R2");

    // R6: zero-crossing clears the count in manual mode
    step(1, 0, 0, 0, 0, 0, "R6");
    idle(3, "R6");

    // R8 and R5: manual overflow wraps and sets the flag, irq gated by enable
    run_to_top("R8");
    idle(3, "R8");
    b_ie = 1; idle(2, "R5");
    b_ie = 0; idle(1, "R5");

    // R11: clear flags
    step(0, 0, 0, 1, 0, 0, "R11");
    idle(2, "R11");

    // R3/R4/R12: automatic overflow with a companion write in the same cycle
    b_auto = 1; b_ie = 1;
    step(0, 1, 3, 0, 0, 0, "R8");  // write ignored in automatic mode
    run_to_top("R3");
    step(0, 0, 0, 0, 2, 'h77, "R12");
    idle(4, "R4");

    // R7: zero-crossing with count >= 0x55 does not range down
    step(1, 0, 0, 0, 0, 0, "R7");
    idle(30, "R7");
    // R7: low zero-crossing ranges down
    step(1, 0, 0, 0, 0, 0, "R7");
    idle(3, "R7");

    // R4: test-select nonzero leaves the indication flag clear
    step(0, 0, 0, 1, 0, 0, "R11");
    b_ts = 1;
    run_to_top("R4");
    idle(3, "R4");
    b_ts = 0;

    // R10: zero-crossing in the overflow cycle wins
    step(0, 0, 0, 1, 0, 0, "R11");
    run_to_top("R10");
    step(1, 0, 0, 0, 0, 0, "R10");
    idle(3, "R10");

    // R9: saturation at EXP_MAX
    b_auto = 0; step(0, 1, EMX, 0, 0, 0, "R9");
    b_auto = 1; step(0, 0, 0, 1, 1, 'h22, "R9");
    run_to_top("R9");
    idle(3, "R9");

    // R9: low zero-crossing at exponent 0 changes nothing
    b_auto = 0; step(0, 1, 0, 0, 0, 0, "R9");
    b_auto = 1; idle(5, "R9");
    step(1, 0, 0, 0, 0, 0, "R9");
    idle(3, "R9");

    // R7: auto step up from exponent 0 then down again
    run_to_top("R3");
    idle(2, "R3");
    step(1, 0, 0, 0, 0, 0, "R6");
    idle(10, "R7");
    step(1, 0, 0, 0, 0, 0, "R7");
    idle(2, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule